// File: doc/BRIEF.md
# Break-framed UART command receiver

This block receives characters on an asynchronous serial line and turns them into 24-bit register-access command words. Each character has a start bit, eight data bits sent least significant bit first, an odd parity bit and at least one stop bit. The line is oversampled sixteen times per bit, and each bit is decided by a majority vote of three samples around its middle.

A break is a character whose eleven bit positions, including the stop position, are all low. In fast mode a break opens a command. The next three good characters are packed into one word and announced with a single-cycle strobe. A break is never reported as a parity or stop-bit error, even though its parity bit does not give odd parity. In slow mode there is no command framing: every good character is handed out as a plain data byte.

Top module: `ubrk_cmd_rx`

## Requirements
- R1: During and after synchronous reset, `cmd_valid`, `data_valid`, `err_parity`, `err_stop` and `err_sync` are low and `cmd_word`/`data_byte` are zero.
- R2: A character is one low start bit, eight data bits with the least significant bit first, a parity bit that makes the nine data and parity bits hold an odd number of ones, and a high stop bit.
- R3: A character with all eleven positions sampled low is a break. In fast mode it opens a new command and raises neither `err_parity` nor `err_stop`.
- R4: The three good characters that follow a break give one `cmd_word`, with the first byte in bits 23:16, the second in 15:8 and the third in 7:0. `cmd_valid` is high for exactly one clock.
- R5: In fast mode, a good character that arrives while no command is open is discarded and pulses `err_sync` for one clock.
- R6: A break that arrives after one or two bytes of a command discards those bytes and starts a new three-byte collection.
- R7: A non-break character whose parity bit does not give odd parity pulses `err_parity`. It closes any open command without producing a word.
- R8: A non-break character whose stop bit samples low pulses `err_stop`. It closes any open command without producing a word.
- R9: `baud_sel`=1 selects the fast rate (bit time `16*FAST_DIV` clocks) with command framing. `baud_sel`=0 selects the slow rate (`16*SLOW_DIV` clocks): each good character appears on `data_byte` with a one-clock `data_valid`, no command or `err_sync` is produced, and an all-low character raises both `err_parity` and `err_stop`.
- R10: A bit is decided by the majority of three samples around its middle, so a disturbance of one sample period does not change the value. A start bit whose middle is high is dropped and produces no output.
- R11: `cmd_valid` and `data_valid` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_sel | input | 1 | 1 = fast rate with command framing, 0 = slow rate with plain data |
| rx_in | input | 1 | Serial line, idle high |
| cmd_word | output | 24 | Assembled command, first byte in the top bits |
| cmd_valid | output | 1 | One-clock strobe for `cmd_word` |
| data_byte | output | 8 | Byte received in slow mode |
| data_valid | output | 1 | One-clock strobe for `data_byte` |
| err_parity | output | 1 | One-clock parity error flag |
| err_stop | output | 1 | One-clock stop-bit error flag |
| err_sync | output | 1 | One-clock flag for a byte with no open command |

## Verification
The bench sends breaks between good bytes and checks that no error strobe appears. A design that tested parity before it recognised a break would report false parity and stop errors there. It restarts a command with a second break after one byte; a receiver that kept its byte count would emit a word mixing bytes from two commands. It also checks byte order and bit order in the word: swapped ends or MSB-first shifting give a wrong value. Short start glitches and a one-sample mid-bit spike probe the vote, where a single-sample decision would produce a spurious character or a corrupted byte. Slow mode is run with a break-shaped character, which must come out as a parity and stop error and never as a command.

// File: rtl/ubrk_pkg.sv
package ubrk_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_RUN  = 2'd1,
    RX_HOLD = 2'd2
  } rx_state_t;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       serr;
    logic       brk;
  } rx_char_t;

  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

endpackage

// File: rtl/ubrk_tick_gen.sv
module ubrk_tick_gen #(
  parameter int FAST_DIV = 312,
  parameter int SLOW_DIV = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic fast,
  output logic tick
);
  localparam int MAXD = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int W = $clog2(MAXD + 1);
  localparam logic [W-1:0] F_LAST = W'(FAST_DIV - 1);
  localparam logic [W-1:0] S_LAST = W'(SLOW_DIV - 1);

  logic [W-1:0] cnt;
  logic         fast_q;
  logic [W-1:0] last;

  assign last = fast ? F_LAST : S_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick   <= 1'b0;
      fast_q <= 1'b1;
    end else begin
      fast_q <= fast;
      tick   <= 1'b0;
      if (fast != fast_q) begin
        cnt <= '0;
      end else if (cnt == last) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ubrk_char_rx.sv
module ubrk_char_rx
  import ubrk_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     rx_in,
  output logic     done,
  output rx_char_t ch
);
  localparam int OSR_W = $clog2(OSR);
  localparam logic [OSR_W-1:0] T_LAST = OSR_W'(OSR - 1);
  localparam logic [OSR_W-1:0] T_S0   = OSR_W'(OSR / 2 - 1);
  localparam logic [OSR_W-1:0] T_S1   = OSR_W'(OSR / 2);
  localparam logic [OSR_W-1:0] T_S2   = OSR_W'(OSR / 2 + 1);
  localparam logic [3:0] BIT_STOP = 4'd10;

  logic [1:0]       sync;
  logic             rxd;
  rx_state_t        state;
  logic [OSR_W-1:0] tcnt;
  logic [3:0]       bidx;
  logic [1:0]       samp;
  logic [8:0]       bits;
  logic             v;

  assign rxd = sync[1];
  assign v   = vote3({samp, rxd});

  always_ff @(posedge clk) begin
    if (rst) begin
      sync  <= 2'b11;
      state <= RX_IDLE;
      tcnt  <= '0;
      bidx  <= '0;
      samp  <= '0;
      bits  <= '0;
      done  <= 1'b0;
      ch    <= '0;
    end else begin
      sync <= {sync[0], rx_in};
      done <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: begin
            if (!rxd) begin
              state <= RX_RUN;
              tcnt  <= '0;
              bidx  <= '0;
            end
          end
          RX_RUN: begin
            tcnt <= (tcnt == T_LAST) ? '0 : tcnt + 1'b1;
            if (tcnt == T_LAST) bidx <= bidx + 1'b1;
            if (tcnt == T_S0 || tcnt == T_S1) samp <= {samp[0], rxd};
            if (tcnt == T_S2) begin
              if (bidx == 4'd0) begin
                if (v) state <= RX_IDLE;
              end else if (bidx == BIT_STOP) begin
                done     <= 1'b1;
                ch.data  <= bits[7:0];
                ch.perr  <= ~(^bits);
                ch.serr  <= ~v;
                ch.brk   <= (bits == 9'd0) && !v;
                state    <= v ? RX_IDLE : RX_HOLD;
              end else begin
                bits <= {v, bits[8:1]};
              end
            end
          end
          RX_HOLD: begin
            if (rxd) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ubrk_framer.sv
module ubrk_framer
  import ubrk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        fast,
  input  logic        done,
  input  rx_char_t    ch,
  output logic [23:0] cmd_word,
  output logic        cmd_valid,
  output logic [7:0]  data_byte,
  output logic        data_valid,
  output logic        err_parity,
  output logic        err_stop,
  output logic        err_sync
);
  logic        open_cmd;
  logic [1:0]  nbytes;
  logic [15:0] acc;
  logic        bad;

  assign bad = ch.perr | ch.serr;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_cmd   <= 1'b0;
      nbytes     <= '0;
      acc        <= '0;
      cmd_word   <= '0;
      cmd_valid  <= 1'b0;
      data_byte  <= '0;
      data_valid <= 1'b0;
      err_parity <= 1'b0;
      err_stop   <= 1'b0;
      err_sync   <= 1'b0;
    end else begin
      cmd_valid  <= 1'b0;
      data_valid <= 1'b0;
      err_parity <= 1'b0;
      err_stop   <= 1'b0;
      err_sync   <= 1'b0;
      if (done) begin
        if (!fast) begin
          open_cmd   <= 1'b0;
          err_parity <= ch.perr;
          err_stop   <= ch.serr;
          if (!bad) begin
            data_byte  <= ch.data;
            data_valid <= 1'b1;
          end
        end else if (ch.brk) begin
          open_cmd <= 1'b1;
          nbytes   <= '0;
        end else if (bad) begin
          open_cmd   <= 1'b0;
          err_parity <= ch.perr;
          err_stop   <= ch.serr;
        end else if (!open_cmd) begin
          err_sync <= 1'b1;
        end else if (nbytes == 2'd2) begin
          cmd_word  <= {acc, ch.data};
          cmd_valid <= 1'b1;
          open_cmd  <= 1'b0;
        end else begin
          acc    <= {acc[7:0], ch.data};
          nbytes <= nbytes + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ubrk_cmd_rx.sv
module ubrk_cmd_rx
  import ubrk_pkg::*;
#(
  parameter int CLK_HZ    = 48_000_000,
  parameter int FAST_BAUD = 9600,
  parameter int SLOW_BAUD = 1200,
  parameter int OSR       = 16,
  parameter int FAST_DIV  = CLK_HZ / (FAST_BAUD * OSR),
  parameter int SLOW_DIV  = CLK_HZ / (SLOW_BAUD * OSR)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        baud_sel,
  input  logic        rx_in,
  output logic [23:0] cmd_word,
  output logic        cmd_valid,
  output logic [7:0]  data_byte,
  output logic        data_valid,
  output logic        err_parity,
  output logic        err_stop,
  output logic        err_sync
);
  logic     tick;
  logic     rx_done;
  rx_char_t rx_ch;
  logic     rx_brk;

  assign rx_brk = rx_ch.brk;

  ubrk_tick_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst(rst), .fast(baud_sel), .tick(tick)
  );

  ubrk_char_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rx_in(rx_in),
    .done(rx_done), .ch(rx_ch)
  );

  ubrk_framer u_frm (
    .clk(clk), .rst(rst), .fast(baud_sel), .done(rx_done), .ch(rx_ch),
    .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .data_byte(data_byte), .data_valid(data_valid),
    .err_parity(err_parity), .err_stop(err_stop), .err_sync(err_sync)
  );
endmodule

// File: rtl/ubrk_cmd_rx_chk.sv
module ubrk_cmd_rx_chk (
  input logic clk,
  input logic rst,
  input logic baud_sel,
  input logic rx_done,
  input logic rx_brk,
  input logic cmd_valid,
  input logic data_valid,
  input logic err_parity,
  input logic err_stop,
  input logic err_sync
);
  AST_BRK_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_brk && baud_sel) |=> (!err_parity && !err_stop)); // R3
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid); // R4
  AST_CMD_FROM_CHAR: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ($past(rx_done) && !$past(rx_brk))); // R4
  AST_SYNC_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    err_sync |-> !cmd_valid); // R5
  AST_ERR_FROM_CHAR: assert property (@(posedge clk) disable iff (rst)
    (err_parity || err_stop || err_sync) |-> $past(rx_done)); // R7
  AST_DATA_SLOW_ONLY: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> !$past(baud_sel)); // R9
  AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && data_valid)); // R11
endmodule

bind ubrk_cmd_rx ubrk_cmd_rx_chk u_chk (
  .clk(clk), .rst(rst), .baud_sel(baud_sel), .rx_done(rx_done), .rx_brk(rx_brk),
  .cmd_valid(cmd_valid), .data_valid(data_valid),
  .err_parity(err_parity), .err_stop(err_stop), .err_sync(err_sync)
);

// File: tb/ubrk_cmd_rx_test.sv
module ubrk_cmd_rx_test;
  localparam int FDIV = 4;
  localparam int SDIV = 32;
  localparam int FBIT = 16 * FDIV;
  localparam int SBIT = 16 * SDIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic baud_sel = 1'b1;
  logic rx_in = 1'b1;
  logic [23:0] cmd_word;
  logic cmd_valid;
  logic [7:0] data_byte;
  logic data_valid;
  logic err_parity, err_stop, err_sync;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;
  logic prev_cmd = 1'b0;

  // model state and expected events (kind: 0 par, 1 stop, 2 sync, 3 data, 4 cmd)
  int exp_kind[$];
  int exp_val[$];
  bit m_open = 0;
  int m_cnt = 0;
  int m_acc = 0;

  always #2 clk = ~clk;

  ubrk_cmd_rx #(.FAST_DIV(FDIV), .SLOW_DIV(SDIV)) uut (
    .clk(clk), .rst(rst), .baud_sel(baud_sel), .rx_in(rx_in),
    .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .data_byte(data_byte), .data_valid(data_valid),
    .err_parity(err_parity), .err_stop(err_stop), .err_sync(err_sync)
  );

  function automatic string req_of(input int k);
    case (k)
      0: return "R7";
      1: return "R8";
      2: return "R5";
      3: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic observe(input int k, input int v);
    checks++;
    if (exp_kind.size() == 0) begin
      errors++;
      $display("FAIL %s unexpected event kind=%0d value=%h expected none", req_of(k), k, v);
    end else begin
      int ek = exp_kind.pop_front();
      int ev = exp_val.pop_front();
      if (ek != k || ev != v) begin
        errors++;
        $display("FAIL %s event kind=%0d value=%h expected kind=%0d value=%h",
                 req_of(ek), k, v, ek, ev);
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      cycles++;
      if (err_parity) observe(0, 0);
      if (err_stop)   observe(1, 0);
      if (err_sync)   observe(2, 0);
      if (data_valid) observe(3, int'(data_byte));
      if (cmd_valid)  observe(4, int'(cmd_word));
      if (cmd_valid && prev_cmd) begin
        checks++; errors++;
        $display("FAIL R4 cmd_valid=1 for two clocks expected one");
      end
      if (cmd_valid && data_valid) begin
        checks++; errors++;
        $display("FAIL R11 cmd_valid=1 data_valid=1 expected not both");
      end
      prev_cmd = cmd_valid;
    end
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog run=%0d cycles expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // model from the requirements
  task automatic model(input logic [7:0] d, input logic p, input logic s);
    bit perr = ($countones({d, p}) % 2) == 0; // R2 odd parity
    bit serr = !s;
    bit brk = (d == 8'd0) && !p && !s;
    if (!baud_sel) begin
      if (perr) begin exp_kind.push_back(0); exp_val.push_back(0); end
      if (serr) begin exp_kind.push_back(1); exp_val.push_back(0); end
      if (!perr && !serr) begin exp_kind.push_back(3); exp_val.push_back(int'(d)); end
      m_open = 0;
    end else if (brk) begin
      m_open = 1; m_cnt = 0; m_acc = 0;                 // R3, R6
    end else if (perr || serr) begin
      if (perr) begin exp_kind.push_back(0); exp_val.push_back(0); end
      if (serr) begin exp_kind.push_back(1); exp_val.push_back(0); end
      m_open = 0;
    end else if (!m_open) begin
      exp_kind.push_back(2); exp_val.push_back(0);
    end else begin
      m_acc = (m_acc << 8) | int'(d);
      m_cnt++;
      if (m_cnt == 3) begin
        exp_kind.push_back(4); exp_val.push_back(m_acc & 24'hFFFFFF);
        m_open = 0;
      end
    end
  endtask

  task automatic drive(input logic [7:0] d, input logic p, input logic s, input int glitch_bit);
    int bc = baud_sel ? FBIT : SBIT;
    int dv = baud_sel ? FDIV : SDIV;
    logic [10:0] fr = {s, p, d, 1'b0};
    model(d, p, s);
    for (int i = 0; i < 11; i++) begin
      @(negedge clk) rx_in = fr[i];
      if (i == glitch_bit) begin
        repeat (bc / 2 - dv / 2) @(negedge clk);
        rx_in = ~fr[i];
        repeat (dv) @(negedge clk);
        rx_in = fr[i];
        repeat (bc - bc / 2 + dv / 2 - dv - 1) @(negedge clk);
      end else begin
        repeat (bc - 1) @(negedge clk);
      end
    end
    @(negedge clk) rx_in = 1'b1;
    repeat (2 * bc) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d);
    drive(d, ~(^d), 1'b1, -1);
  endtask

  task automatic send_break();
    drive(8'd0, 1'b0, 1'b0, -1);
  endtask

  task automatic settle(input string req);
    repeat (3 * SBIT) @(negedge clk);
    checks++;
    if (exp_kind.size() != 0) begin
      errors++;
      $display("FAIL %s missing %0d events expected 0", req, exp_kind.size());
      exp_kind.delete(); exp_val.delete();
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    checks++;
    if (cmd_valid || data_valid || err_parity || err_stop || err_sync ||
        cmd_word != 0 || data_byte != 0) begin
      errors++;
      $display("FAIL R1 outputs=%b%b%b%b%b word=%h byte=%h expected zero",
               cmd_valid, data_valid, err_parity, err_stop, err_sync, cmd_word, data_byte);
    end
    @(negedge clk) rst = 1'b0;
    repeat (10) @(negedge clk);

    // R3 R4 R2: break then three bytes, first byte on top, LSB-first bits
    send_break(); send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h81);
    settle("R4");
    send_break(); send_byte(8'h01); send_byte(8'h80); send_byte(8'hFE);
    settle("R2");
    // R5 byte with no open command, and after a completed command
    send_byte(8'h55); settle("R5");
    // R6 restart after a partial command
    send_break(); send_byte(8'h11); send_break();
    send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    settle("R6");
    // R7 parity error mid-command, then orphan byte
    send_break(); send_byte(8'h10);
    drive(8'h10, 1'b1, 1'b1, -1);
    send_byte(8'h20);
    settle("R7");
    // R8 stop-bit error (nonzero data, low stop)
    send_break(); drive(8'h6B, ~(^8'h6B), 1'b0, -1);
    send_byte(8'h77);
    settle("R8");
    // R10 short start glitch dropped, then single-sample spike in data bit 3
    @(negedge clk) rx_in = 1'b0;
    repeat (3 * FDIV) @(negedge clk);
    rx_in = 1'b1;
    repeat (2 * FBIT) @(negedge clk);
    send_break(); drive(8'hC3, ~(^8'hC3), 1'b1, 4);
    send_byte(8'h0F); drive(8'h96, ~(^8'h96), 1'b1, 7);
    settle("R10");
    // R9 slow mode: plain bytes and a break-shaped character
    @(negedge clk) baud_sel = 1'b0;
    repeat (4 * SDIV) @(negedge clk);
    send_byte(8'h5A); send_break(); send_byte(8'hE7);
    drive(8'h00, 1'b1, 1'b1, -1);
    settle("R9");
    // back to fast mode: framing works again (R3, R4)
    @(negedge clk) baud_sel = 1'b1;
    repeat (4 * FDIV) @(negedge clk);
    send_break(); send_byte(8'hDE); send_byte(8'hAD); send_byte(8'hBE);
    settle("R3");

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule